// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one burst access to a synchronous DRAM row. A start strobe supplies a starting column and whether the access is a write. From then on the block emits one column per enabled clock, together with a valid flag and a flag that marks the final beat. The burst length, the address order and the write-single option come from a mode word. The block samples that word only when a burst starts.

The burst length can be 1, 2, 4 or 8 beats, or a full page that wraps around the row until something ends it. In sequential order the low bits count upward and wrap inside the aligned block. In interleaved order the beat number is XORed into the start column. A stop strobe ends a burst; it stands for either a burst-stop command or a precharge. A new start ends the current burst at once. When the clock enable is low, the block freezes completely. The latency field of the mode word is not used here: the data pipeline that applies it sits outside this block.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and whenever no burst is running, colValid=0, colLast=0, colOut=0 and lenError=0 (lenError only until the first start).
- R2: A start (startStb=1 with clkEn=1) shows colValid=1 and colOut=startCol after that edge. This holds even while another burst is running and even when stopStb is also high.
- R3: Length code modeWord[2:0] 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. colValid falls at the first enabled edge after the final beat.
- R4: With modeWord[3]=0 (sequential), beat i is the start column with its low log2(length) bits replaced by (start+i) mod length. The upper bits do not change. Example: length 4 from column 2 gives 2,3,0,1.
- R5: With modeWord[3]=1 (interleaved), beat i is the start column XOR i. Example: length 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R6: Code 111 with modeWord[3]=0 is a full page. The column counts up modulo 2^COL_W without end until it is stopped or restarted.
- R7: colLast is 1 exactly on the final beat of a fixed-length burst and never during a full-page burst.
- R8: stopStb=1 with clkEn=1 and no start sets colValid to 0 after that edge.
- R9: While clkEn=0, all outputs hold their values and startStb and stopStb are ignored. Advancing resumes on the first edge with clkEn=1.
- R10: With modeWord[9]=1, a burst started with startIsWrite=1 is one beat long. Reads keep the programmed length.
- R11: Codes 100, 101 and 110, and code 111 with modeWord[3]=1, run a one-beat burst and set lenError=1. lenError keeps its value until the next start.
- R12: The mode word is captured at the start edge. Changes to it during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Clock enable; low suspends the block |
| startStb | input | 1 | Begin a burst at startCol |
| startCol | input | COL_W | Starting column |
| startIsWrite | input | 1 | The starting access is a write |
| stopStb | input | 1 | End the running burst (burst stop or precharge) |
| modeWord | input | 12 | Mode word: [2:0] length, [3] order, [9] write-single |
| colOut | output | COL_W | Current column (0 when idle) |
| colValid | output | 1 | colOut holds a beat |
| colLast | output | 1 | Final beat of a fixed-length burst |
| lenError | output | 1 | The last start used a reserved length setting |

## Verification
Beat 0 is due right after the edge that samples a start. Each later beat follows exactly one enabled edge. colValid falls on the enabled edge after the final beat or after a stop, and a suspended edge changes nothing. The bench changes inputs 1 ns after a rising edge and samples 1 ns after the next edge. Each check therefore looks at the cycle that the edge count above predicts. The expected columns come from a block-offset formula and literal order tables, not from the design's counter-and-mask structure.

// File: rtl/burst_col_pkg.sv
`timescale 1ns/1ps
package burst_col_pkg;
  // Mode word field positions (decoded by neighbouring logic, so fixed)
  localparam int LenLsb     = 0;
  localparam int TypeBit    = 3;
  localparam int WsingleBit = 9;

  localparam logic [2:0] LenOne   = 3'b000;
  localparam logic [2:0] LenTwo   = 3'b001;
  localparam logic [2:0] LenFour  = 3'b010;
  localparam logic [2:0] LenEight = 3'b011;
  localparam logic [2:0] LenPage  = 3'b111;

  // Control to datapath strobes
  typedef struct packed {
    logic load;     // capture a new burst
    logic advance;  // step to the next beat
    logic clear;    // burst finished
  } colStrobe_t;
endpackage

// File: rtl/burst_col_ctrl.sv
`timescale 1ns/1ps
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clkEn,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic       finalBeat,
  output colStrobe_t strobe,
  output logic       active
);
  always_comb begin
    strobe = '0;
    if (clkEn) begin
      if (startStb)                           strobe.load    = 1'b1;
      else if (active && (stopStb || finalBeat)) strobe.clear = 1'b1;
      else if (active)                        strobe.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            active <= 1'b0;
    else if (strobe.load)  active <= 1'b1;
    else if (strobe.clear) active <= 1'b0;
  end
endmodule

// File: rtl/burst_col_path.sv
`timescale 1ns/1ps
module burst_col_path
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  colStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic             startIsWrite,
  input  logic [2:0]       lenCode,
  input  logic             ilvSel,
  input  logic             writeSingle,
  output logic [COL_W-1:0] addr,
  output logic             finalBeat,
  output logic             lenError
);
  logic [COL_W-1:0] decMask;
  logic             decFull, decErr;

  always_comb begin
    decMask = '0;
    decFull = 1'b0;
    decErr  = 1'b0;
    case (lenCode)
      LenOne:   decMask = '0;
      LenTwo:   decMask = COL_W'(1);
      LenFour:  decMask = COL_W'(3);
      LenEight: decMask = COL_W'(7);
      LenPage: begin
        if (ilvSel) decErr = 1'b1;
        else begin
          decMask = '1;
          decFull = 1'b1;
        end
      end
      default:  decErr = 1'b1;
    endcase
    if (writeSingle && startIsWrite) begin
      decMask = '0;
      decFull = 1'b0;
    end
  end

  logic [COL_W-1:0] baseCol, beatCnt, lenMask;
  logic             fullPage, ilvReg, errReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseCol  <= '0;
      beatCnt  <= '0;
      lenMask  <= '0;
      fullPage <= 1'b0;
      ilvReg   <= 1'b0;
      errReg   <= 1'b0;
    end else if (strobe.load) begin
      baseCol  <= startCol;
      beatCnt  <= '0;
      lenMask  <= decMask;
      fullPage <= decFull;
      ilvReg   <= ilvSel;
      errReg   <= decErr;
    end else if (strobe.advance) begin
      beatCnt  <= beatCnt + COL_W'(1);
    end
  end

  logic [COL_W-1:0] seqAddr, ilvAddr, stepSum;
  assign stepSum   = baseCol + beatCnt;
  assign seqAddr   = (baseCol & ~lenMask) | (stepSum & lenMask);
  assign ilvAddr   = baseCol ^ beatCnt;
  assign addr      = ilvReg ? ilvAddr : seqAddr;
  assign finalBeat = !fullPage && (beatCnt == lenMask);
  assign lenError  = errReg;
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clkEn,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic             startIsWrite,
  input  logic             stopStb,
  input  logic [11:0]      modeWord,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             colLast,
  output logic             lenError
);
  colStrobe_t       strobe;
  logic             active, finalBeat;
  logic [COL_W-1:0] addr;
  logic             unusedModeBits;

  assign unusedModeBits = ^{modeWord[11:10], modeWord[8:4]};

  burst_col_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .startStb(startStb),
    .stopStb(stopStb), .finalBeat(finalBeat), .strobe(strobe), .active(active)
  );

  burst_col_path #(.COL_W(COL_W)) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .startCol(startCol),
    .startIsWrite(startIsWrite), .lenCode(modeWord[LenLsb +: 3]),
    .ilvSel(modeWord[TypeBit]), .writeSingle(modeWord[WsingleBit]),
    .addr(addr), .finalBeat(finalBeat), .lenError(lenError)
  );

  assign colOut   = active ? addr : '0;
  assign colValid = active;
  assign colLast  = active && finalBeat;
endmodule

// File: rtl/burst_col_gen_chk.sv
`timescale 1ns/1ps
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clkEn,
  input logic             startStb,
  input logic             stopStb,
  input logic             startIsWrite,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       lenCode,
  input logic             ilvBit,
  input logic             wsBit,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             colLast,
  input logic             lenError
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !colValid |-> (colOut == '0) && !colLast);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && startStb |=> colValid && (colOut == $past(startCol)));

  a_r3_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && colLast && !startStb |=> !colValid);

  a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && startStb && (lenCode == 3'b111) && !ilvBit && !(wsBit && startIsWrite)
    |=> !colLast);

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    colLast |-> colValid);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && stopStb && !startStb |=> !colValid);

  a_r9_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clkEn |=> $stable(colOut) && $stable(colValid) && $stable(colLast) && $stable(lenError));

  a_r11_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && startStb && lenCode[2] && ((lenCode[1:0] != 2'b11) || ilvBit) |=> lenError);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .startStb(startStb), .stopStb(stopStb),
  .startIsWrite(startIsWrite), .startCol(startCol), .lenCode(modeWord[2:0]),
  .ilvBit(modeWord[3]), .wsBit(modeWord[9]), .colOut(colOut), .colValid(colValid),
  .colLast(colLast), .lenError(lenError)
);

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0, clkEn = 1'b1;
  logic startStb = 1'b0, stopStb = 1'b0, startIsWrite = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [11:0] modeWord = '0;
  logic [COL_W-1:0] colOut;
  logic colValid, colLast, lenError;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  int seqOrder [4] = '{2, 3, 0, 1};
  int ilvOrder [8] = '{5, 4, 7, 6, 1, 0, 3, 2};

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .startStb(startStb),
    .startCol(startCol), .startIsWrite(startIsWrite), .stopStb(stopStb),
    .modeWord(modeWord), .colOut(colOut), .colValid(colValid),
    .colLast(colLast), .lenError(lenError)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] mk(logic [2:0] len, bit ilv, bit ws);
    return {2'b00, ws, 2'b00, 3'b010, ilv, len};
  endfunction

  function automatic int refCol(int base, int i, int beats, bit ilv);
    if (ilv) return base ^ i;
    return (base - (base % beats)) + (((base % beats) + i) % beats);
  endfunction

  task automatic launch(logic [11:0] m, int col, bit wr);
    modeWord = m; startCol = COL_W'(col); startIsWrite = wr; startStb = 1'b1;
    tick();
    startStb = 1'b0;
  endtask

  task automatic runFixed(string req, logic [11:0] m, int col, bit wr, int beats, bit ilv);
    launch(m, col, wr);
    for (int i = 0; i < beats; i++) begin
      check(req, "col", colOut, refCol(col, i, beats, ilv));
      check(req, "valid", colValid, 1);
      check("R7", "last", colLast, (i == beats - 1));
      if (i < beats - 1) tick();
    end
    tick();
    check(req, "valid after end", colValid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    check("R1", "valid in reset", colValid, 0);
    rst_n = 1'b1;
    tick();
    check("R1", "col", colOut, 0);
    check("R1", "valid", colValid, 0);
    check("R1", "last", colLast, 0);
    check("R1", "err", lenError, 0);
  endtask

  task automatic t_lengths();
    runFixed("R3", mk(3'b000, 0, 0), 77, 0, 1, 0);
    runFixed("R3", mk(3'b001, 0, 0), 9, 0, 2, 0);
    runFixed("R3", mk(3'b010, 0, 0), 100, 0, 4, 0);
    runFixed("R4", mk(3'b011, 0, 0), 13, 0, 8, 0);
    runFixed("R5", mk(3'b010, 1, 0), 6, 0, 4, 1);
    check("R1", "idle col", colOut, 0);
  endtask

  task automatic t_orders();
    launch(mk(3'b010, 0, 0), 2, 0);
    for (int i = 0; i < 4; i++) begin
      check("R4", "seq order", colOut, seqOrder[i]);
      tick();
    end
    check("R4", "seq end", colValid, 0);
    launch(mk(3'b011, 1, 0), 5, 0);
    for (int i = 0; i < 8; i++) begin
      check("R5", "ilv order", colOut, ilvOrder[i]);
      tick();
    end
    check("R5", "ilv end", colValid, 0);
  endtask

  task automatic t_fullPage();
    bit sawLast = 1'b0;
    bit dropped = 1'b0;
    launch(mk(3'b111, 0, 0), 510, 0);
    for (int i = 0; i < 4; i++) begin
      check("R6", "page wrap", colOut, (510 + i) % PAGE);
      tick();
    end
    for (int i = 0; i < 600; i++) begin
      if (colLast) sawLast = 1'b1;
      if (!colValid) dropped = 1'b1;
      tick();
    end
    check("R7", "no last in page", sawLast, 0);
    check("R6", "page never ends", dropped, 0);
    check("R6", "page col", colOut, (510 + 604) % PAGE);
    stopStb = 1'b1;
    tick();
    stopStb = 1'b0;
    check("R8", "stop ends page", colValid, 0);
  endtask

  task automatic t_suspend();
    launch(mk(3'b011, 0, 0), 0, 0);
    tick();
    check("R9", "pre-suspend", colOut, 1);
    clkEn = 1'b0; startStb = 1'b1; startCol = 100; stopStb = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R9", "frozen col", colOut, 1);
      check("R9", "frozen valid", colValid, 1);
    end
    clkEn = 1'b1; startStb = 1'b0; stopStb = 1'b0;
    tick();
    check("R9", "resume", colOut, 2);
    stopStb = 1'b1;
    tick();
    stopStb = 1'b0;
    check("R8", "stop mid burst", colValid, 0);
  endtask

  task automatic t_restart();
    launch(mk(3'b011, 0, 0), 40, 0);
    tick(); tick();
    check("R2", "before restart", colOut, 42);
    stopStb = 1'b1;
    launch(mk(3'b001, 0, 0), 3, 0);
    stopStb = 1'b0;
    check("R2", "restart col", colOut, 3);
    check("R2", "restart valid", colValid, 1);
    tick();
    check("R2", "restart beat1", colOut, 2);
    check("R7", "restart last", colLast, 1);
    tick();
    check("R2", "restart end", colValid, 0);
  endtask

  task automatic t_modeHold();
    launch(mk(3'b010, 0, 0), 4, 0);
    modeWord = mk(3'b011, 1, 1);
    startIsWrite = 1'b1;
    for (int i = 1; i < 4; i++) begin
      tick();
      check("R12", "held order", colOut, 4 + i);
    end
    check("R12", "held last", colLast, 1);
    tick();
    check("R12", "held end", colValid, 0);
  endtask

  task automatic t_writeSingle();
    runFixed("R10", mk(3'b011, 0, 1), 20, 1, 1, 0);
    runFixed("R10", mk(3'b011, 0, 1), 20, 0, 8, 0);
    runFixed("R10", mk(3'b111, 0, 1), 30, 1, 1, 0);
  endtask

  task automatic t_reserved();
    runFixed("R11", mk(3'b101, 0, 0), 9, 0, 1, 0);
    check("R11", "err held", lenError, 1);
    runFixed("R11", mk(3'b111, 1, 0), 12, 0, 1, 0);
    check("R11", "err ilv page", lenError, 1);
    launch(mk(3'b010, 0, 0), 0, 0);
    check("R11", "err cleared", lenError, 0);
    repeat (4) tick();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lengths();
    t_orders();
    t_fullPage();
    t_suspend();
    t_restart();
    t_modeHold();
    t_writeSingle();
    t_reserved();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule